// File: doc/BRIEF.md
# Grayscale Composite Video Timing Generator

This block produces line and frame timing for a monochrome composite picture. It runs from a single system clock. Each clock it presents a 2-bit level code to an external resistor-ladder DAC. The codes mean: 00 is sync level (0 V), 01 is black (about 0.3 V), 10 is gray (about 0.7 V) and 11 is white (about 1 V). Code 00 serves as the sync tip, so no separate sync pin exists. With a 3.6864 MHz clock the fixed 234-clock line gives a 63.5 µs line period.

A visible line has four parts, in order:
- a sync pulse;
- a black back porch;
- an active region built from a nine-entry table of gray levels, with each entry shown for 16 clocks and the rest of the region filled with black;
- a black front porch.

After the visible lines, a short run of vertical-blanking lines follows. These lines use an inverted shape: a black pulse in the sync slot, then sync level for the rest of the line. The number of blanking lines can be changed through a small configuration write. The table can also be rewritten while the picture runs; each change waits for a line boundary. Strobes mark the start of each line and of each frame, and the current table index is brought out so that a pixel source can follow the raster.

Top module: `vid_gray_timing`

## Requirements
- R1: Reset is synchronous and active-high. While reset is held, the block sits at column 0 of visible row 0 with the level at code 00 and both strobes low. On the first clock after release it is still at that point, and now frame_start and line_start are high. Every table entry resets to code 01, and the blanking line count resets to 2.
- R2: Every line, visible or blanking, lasts exactly 234 clocks. line_start is high for one clock at the first clock (column 0) of each line.
- R3: On a visible line, columns 0 to 15 carry code 00 (sync) and columns 16 to 34 carry code 01 (black back porch).
- R4: On a visible line, columns 35 to 178 form nine slots of 16 clocks each. Slot k, for k from 0 to 8, carries table entry k.
- R5: On a visible line, columns 179 to 233 carry code 01. This covers the 25 black clocks after the last slot and the 30-clock front porch.
- R6: A frame begins with 242 visible lines (rows 0 to 241). The blanking lines follow them.
- R7: On a blanking line, columns 0 to 15 carry code 01 and columns 16 to 233 carry code 00.
- R8: The blanking count is an 8-bit setting, written when vbl_we is high. It is captured at the last clock of row 241, and a captured value of 0 counts as 1. A write made earlier than that clock sets the length of the blanking interval that follows it. The interval already under way keeps its length.
- R9: A table write with tbl_we high stores tbl_lvl into entry tbl_addr. A write in any clock of a line, including its last clock, shows from the next line onward and never changes the line in progress. Addresses 9 to 15 change no entry.
- R10: frame_start is high for exactly one clock, the first clock of row 0, and always together with line_start.
- R11: tbl_index is k during slot k. It is 0 on blanking lines and at visible columns 0 to 34. It is 9 at visible columns 179 to 233.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table entry address |
| tbl_lvl | input | 2 | Level code to store |
| vbl_we | input | 1 | Blanking count write enable |
| vbl_lines | input | 8 | Blanking line count to store |
| video_lvl | output | 2 | Level code to the DAC |
| line_start | output | 1 | First clock of every line |
| frame_start | output | 1 | First clock of visible row 0 |
| tbl_index | output | 4 | Table slot now on screen |

## Verification
A wrong column count appears at once as a level edge that comes early or late, or as a line_start that comes early or late. Within at most one line it also shifts every later sync pulse. A wrong row count or a wrong blanking length stays hidden until the frame boundary. It then appears as an inverted sync shape on a row that should be visible, or as frame_start arriving a line early or late, so full frames must be run under different blanking settings. A table that commits at the wrong moment shows as a slot that changes inside a line, or as a change that lands one line late. That is why writes are placed at the last clock of a line and in the middle of lines.

// File: rtl/vid_pkg.sv
package vid_pkg;

  typedef enum logic [1:0] {
    LV_SYNC  = 2'b00,
    LV_BLACK = 2'b01,
    LV_GRAY  = 2'b10,
    LV_WHITE = 2'b11
  } vid_lvl_e;

  // True when column c lies inside [lo, lo+len)
  function automatic logic in_span(input int c, input int lo, input int len);
    return (c >= lo) && (c < lo + len);
  endfunction

  // Slot number of column c, counted from the first active column
  function automatic int slot_of(input int c, input int lo, input int width);
    return (c - lo) / width;
  endfunction

  // A captured blanking count of zero still yields one line
  function automatic int vbl_eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/vid_line_timer.sv
module vid_line_timer #(
  parameter int LINE_CLKS = 234,
  parameter int VIS_LINES = 242,
  parameter int VBL_W     = 8,
  parameter int VBL_RESET = 2,
  parameter int COL_W     = $clog2(LINE_CLKS),
  parameter int ROW_W     = $clog2(VIS_LINES + (1 << VBL_W))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vbl_we,
  input  logic [VBL_W-1:0] vbl_data,
  output logic [COL_W-1:0] col,
  output logic             blank,
  output logic             line_end,
  output logic             line_start,
  output logic             frame_start
);
  import vid_pkg::*;

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [VBL_W-1:0] vbl_cfg_q, vbl_cur_q;
  logic             last_vis, last_row;

  assign col      = col_q;
  assign blank    = row_q >= ROW_W'(VIS_LINES);
  assign line_end = col_q == COL_W'(LINE_CLKS - 1);
  assign last_vis = row_q == ROW_W'(VIS_LINES - 1);
  assign last_row = blank && (row_q == ROW_W'(VIS_LINES - 1) + ROW_W'(vbl_cur_q));

  assign line_start  = !rst && (col_q == '0);
  assign frame_start = line_start && (row_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      row_q     <= '0;
      vbl_cfg_q <= VBL_W'(VBL_RESET);
      vbl_cur_q <= VBL_W'(VBL_RESET);
    end else begin
      if (vbl_we) vbl_cfg_q <= vbl_data;
      if (line_end) begin
        col_q <= '0;
        if (last_vis) vbl_cur_q <= VBL_W'(vbl_eff(int'(vbl_cfg_q)));
        row_q <= last_row ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assert_col_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    line_end |=> line_start);
  assert_strobe_once_R2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);
  assert_vis_to_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (line_end && last_vis) |=> (blank && !frame_start));
  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (line_end && last_row) |=> frame_start);

endmodule

// File: rtl/vid_level_table.sv
module vid_level_table #(
  parameter int TBL_N = 9,
  parameter int IDX_W = $clog2(TBL_N + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [1:0]            wr_lvl,
  input  logic                  commit,
  output logic [TBL_N-1:0][1:0] live
);
  import vid_pkg::*;

  logic [TBL_N-1:0][1:0] stage;
  logic [TBL_N-1:0]      hit;

  // One address decoder per entry; addresses at or above TBL_N hit nothing
  for (genvar i = 0; i < TBL_N; i++) begin : g_hit
    assign hit[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TBL_N; i++) begin
        stage[i] <= LV_BLACK;
        live[i]  <= LV_BLACK;
      end
    end else begin
      for (int i = 0; i < TBL_N; i++) begin
        if (hit[i]) stage[i] <= wr_lvl;
        // Forward a write that lands on the commit clock itself
        if (commit) live[i] <= hit[i] ? wr_lvl : stage[i];
      end
    end
  end

  assert_live_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(live));

endmodule

// File: rtl/vid_pixel_mux.sv
module vid_pixel_mux #(
  parameter int SYNC_CLKS = 16,
  parameter int BACK_CLKS = 19,
  parameter int SLOT_CLKS = 16,
  parameter int TBL_N     = 9,
  parameter int COL_W     = 8,
  parameter int IDX_W     = $clog2(TBL_N + 1)
) (
  input  logic [COL_W-1:0]      col,
  input  logic                  blank,
  input  logic [TBL_N-1:0][1:0] live,
  output logic [1:0]            lvl,
  output logic [IDX_W-1:0]      idx
);
  import vid_pkg::*;

  localparam int ACT_LO  = SYNC_CLKS + BACK_CLKS;
  localparam int ACT_LEN = TBL_N * SLOT_CLKS;

  int c;
  logic [IDX_W-1:0] sel;

  always_comb begin
    c   = int'(col);
    sel = '0;
    idx = '0;
    lvl = LV_BLACK;
    if (blank) begin
      lvl = in_span(c, 0, SYNC_CLKS) ? LV_BLACK : LV_SYNC;
    end else if (in_span(c, 0, SYNC_CLKS)) begin
      lvl = LV_SYNC;
    end else if (c < ACT_LO) begin
      lvl = LV_BLACK;
    end else if (in_span(c, ACT_LO, ACT_LEN)) begin
      sel = IDX_W'(slot_of(c, ACT_LO, SLOT_CLKS));
      idx = sel;
      lvl = live[sel];
    end else begin
      idx = IDX_W'(TBL_N);
    end
  end

endmodule

// File: rtl/vid_gray_timing.sv
module vid_gray_timing #(
  parameter int LINE_CLKS = 234,
  parameter int SYNC_CLKS = 16,
  parameter int BACK_CLKS = 19,
  parameter int VIS_LINES = 242,
  parameter int TBL_N     = 9,
  parameter int SLOT_CLKS = 16,
  parameter int VBL_W     = 8,
  parameter int VBL_RESET = 2,
  parameter int IDX_W     = $clog2(TBL_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [1:0]       tbl_lvl,
  input  logic             vbl_we,
  input  logic [VBL_W-1:0] vbl_lines,
  output logic [1:0]       video_lvl,
  output logic             line_start,
  output logic             frame_start,
  output logic [IDX_W-1:0] tbl_index
);
  localparam int COL_W = $clog2(LINE_CLKS);

  logic [COL_W-1:0]      col;
  logic                  blank, line_end;
  logic [TBL_N-1:0][1:0] live;

  vid_line_timer #(
    .LINE_CLKS(LINE_CLKS), .VIS_LINES(VIS_LINES),
    .VBL_W(VBL_W), .VBL_RESET(VBL_RESET), .COL_W(COL_W)
  ) u_timer (
    .clk(clk), .rst(rst), .vbl_we(vbl_we), .vbl_data(vbl_lines),
    .col(col), .blank(blank), .line_end(line_end),
    .line_start(line_start), .frame_start(frame_start)
  );

  vid_level_table #(.TBL_N(TBL_N), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(tbl_we), .wr_idx(tbl_addr),
    .wr_lvl(tbl_lvl), .commit(line_end), .live(live)
  );

  vid_pixel_mux #(
    .SYNC_CLKS(SYNC_CLKS), .BACK_CLKS(BACK_CLKS), .SLOT_CLKS(SLOT_CLKS),
    .TBL_N(TBL_N), .COL_W(COL_W), .IDX_W(IDX_W)
  ) u_mux (
    .col(col), .blank(blank), .live(live), .lvl(video_lvl), .idx(tbl_index)
  );

  assert_sync_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (line_start && !blank) |-> video_lvl == 2'b00);
  assert_inv_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (line_start && blank) |-> video_lvl == 2'b01);
  assert_frame_on_line_R10: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);
  assert_frame_once_R10: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  assert_black_tail_R5: assert property (@(posedge clk) disable iff (rst)
    (!blank && tbl_index == IDX_W'(TBL_N)) |-> video_lvl == 2'b01);
  assert_index_range_R11: assert property (@(posedge clk) disable iff (rst)
    tbl_index <= IDX_W'(TBL_N));

endmodule

// File: tb/sim_vid_gray_timing.sv
module sim_vid_gray_timing;

  typedef struct {
    int         line;
    int         col;
    bit         blank;
    logic [1:0] lvl;
    logic [3:0] idx;
    logic       ls;
    logic       fs;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [1:0] tbl_lvl = '0;
  logic       vbl_we = 1'b0;
  logic [7:0] vbl_lines = '0;
  logic [1:0] video_lvl;
  logic       line_start, frame_start;
  logic [3:0] tbl_index;

  int   checks = 0;
  int   errors = 0;
  bit   run = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];
  int   bench_tbl[9];
  int   pat_a[9] = '{2, 3, 2, 1, 3, 1, 2, 3, 2};

  always #4 clk = ~clk;

  vid_gray_timing u0 (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_lvl(tbl_lvl), .vbl_we(vbl_we), .vbl_lines(vbl_lines),
    .video_lvl(video_lvl), .line_start(line_start),
    .frame_start(frame_start), .tbl_index(tbl_index)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Expected waveform, restated from the requirements
  function automatic string region_req(input bit blank, input int c);
    if (blank)   return "R7";
    if (c < 35)  return "R3";
    if (c < 179) return "R4";
    return "R5";
  endfunction

  task automatic push_line(input int line);
    for (int c = 0; c < 234; c++) begin
      exp_t e;
      e.line  = line;
      e.col   = c;
      e.blank = (line >= 242);
      e.ls    = (c == 0);
      e.fs    = (c == 0) && (line == 0);
      if (e.blank) begin
        e.lvl = (c < 16) ? 2'd1 : 2'd0;
        e.idx = 4'd0;
      end else if (c < 16) begin
        e.lvl = 2'd0; e.idx = 4'd0;
      end else if (c < 35) begin
        e.lvl = 2'd1; e.idx = 4'd0;
      end else if (c < 179) begin
        e.idx = 4'((c - 35) >> 4);
        e.lvl = 2'(bench_tbl[(c - 35) >> 4]);
      end else begin
        e.lvl = 2'd1; e.idx = 4'd9;
      end
      q.push_back(e);
    end
  endtask

  task automatic wr_tbl(input int a, input int v);
    tbl_we   = 1'b1;
    tbl_addr = 4'(a);
    tbl_lvl  = 2'(v);
    if (a < 9) bench_tbl[a] = v;  // R9: addresses 9..15 leave the table alone
  endtask

  task automatic wr_vbl(input int v);
    vbl_we    = 1'b1;
    vbl_lines = 8'(v);
  endtask

  // Monitor: pops one expected item per clock and compares at the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (run && !done) begin
        if (q.size() == 0) begin
          check("R2", "expectation queue empty", 0, 1);
        end else begin
          exp_t e;
          string tag;
          e = q.pop_front();
          tag = $sformatf("row %0d col %0d", e.line, e.col);
          check(region_req(e.blank, e.col), {"level ", tag}, int'(video_lvl), int'(e.lvl));
          check("R2", {"line_start ", tag}, int'(line_start), int'(e.ls));
          check("R10", {"frame_start ", tag}, int'(frame_start), int'(e.fs));
          check("R11", {"tbl_index ", tag}, int'(tbl_index), int'(e.idx));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check("R2", "watchdog expired", 1, 0);
    finish_run();
  end

  // Driver
  initial begin
    int line, frame, fv, cfg, nl;
    for (int i = 0; i < 9; i++) bench_tbl[i] = 1;
    line = 0; frame = 0; fv = 2; cfg = 2;
    repeat (3) @(negedge clk);
    #1;
    // R1: state while reset is held
    check("R1", "level in reset", int'(video_lvl), 0);
    check("R1", "line_start in reset", int'(line_start), 0);
    check("R1", "frame_start in reset", int'(frame_start), 0);
    check("R1", "tbl_index in reset", int'(tbl_index), 0);
    push_line(0);  // R1: first line after release shows black table entries
    @(negedge clk);
    rst = 1'b0;
    run = 1'b1;
    while (!(frame == 3 && line == 2)) begin
      for (int c = 0; c < 234; c++) begin
        tbl_we = 1'b0;
        vbl_we = 1'b0;
        if (frame == 0 && line == 0 && c >= 5 && c <= 13) wr_tbl(c - 5, pat_a[c - 5]);
        if (frame == 0 && line == 0 && c == 20) wr_tbl(12, 0);  // R9 ignored address
        if (frame == 0 && line == 3 && c == 233) wr_tbl(4, 2);  // R9 last-clock write
        if (frame == 0 && line == 10 && c == 50) wr_tbl(0, 3);  // R9 mid-line write
        if (frame == 0 && line == 242 && c == 10) begin wr_vbl(0); cfg = 0; end  // R8 zero
        if (frame == 0 && line == 243 && c == 100) wr_tbl(8, 0);
        if (frame == 1 && line == 242 && c == 10) begin wr_vbl(3); cfg = 3; end  // R8 three
        if (c == 233) begin
          // R6: rows 0..241 visible, then fv blanking rows; R8 capture
          if (line == 241) fv = (cfg == 0) ? 1 : cfg;
          nl = (line == 241 + fv) ? 0 : line + 1;
          if (nl == 0) frame++;
          push_line(nl);
          line = nl;
        end
        @(negedge clk);
      end
    end
    run = 1'b0;
    finish_run();
  end

endmodule